// File: doc/BRIEF.md
# Multi-Channel Edge/Center-Aligned PWM Timer

This block generates up to eight pulse-width-modulated outputs from one shared 16-bit counter. The counter advances on a tick taken from one of three clock-enable sources (every system clock, a fixed-rate enable, or an external enable). The tick then passes through a power-of-two prescaler. Software programs the block through a simple word-addressed write/read bus. It sets the counter start value, the modulo (top) value, a compare value and mode bits for each channel, and two pin-override registers: a per-channel mask and a per-channel idle level.

One control bit picks the counting shape. In edge-aligned mode the counter climbs from the start value to the modulo value and jumps back. In center-aligned mode it climbs to the modulo value and descends to the start value again, which gives symmetric pulses centred on the top of the count. Writes to the modulo and compare values land in buffer registers. The counter copies them into its working set only at its period boundary, so a running waveform never sees a half-updated period.

Top module: `pwm_multi_timer`

## Requirements
- R1: Registers read back combinationally at their word offsets: control 0x00 (bit 5 center mode, bits 4:3 clock source, bits 2:0 prescale), counter 0x04, modulo 0x08, channel n mode 0x0C+8n (bit 5 PWM enable, bit 3 high-true, bit 2 low-true), channel n compare 0x10+8n, start value 0x4C, idle levels 0x5C, mask 0x60. The modulo and compare offsets return the buffered (last written) value, and any other offset reads zero.
- R2: Clock source 0 freezes the counter; 1 advances on every clock, 2 on each cycle with `fix_tick` high, 3 on each cycle with `ext_tick` high.
- R3: The prescaler divides the selected source by 2^PS, with PS from 0 to 7, so the counter moves once every 2^PS source enables.
- R4: Any write to the counter offset reloads the counter with the start value and restarts center counting in its rising half.
- R5: With bit 5 clear the counter runs from the start value up to the modulo value and reloads. The period is MOD−START+1 ticks, and a channel is active while the count is below its compare value, i.e. for CV−START ticks.
- R6: With bit 5 set the counter rises to the modulo value and falls back to the start value. The period is 2·(MOD−START) ticks and a channel is active for 2·(CV−START) ticks.
- R7: A compare value at or below the start value gives no active time. A value above the modulo value (edge) or at or above it (center) keeps the channel active for the whole period.
- R8: Mode bit 2 set makes the channel low-true (active phase drives 0, inactive drives 1). Otherwise it is high-true (active drives 1).
- R9: A set mask bit forces that channel to its inactive level, and this overrides every other rule.
- R10: While the clock source is 0, or while a channel's PWM-enable bit is clear, an unmasked channel drives its idle-level bit.
- R11: Modulo and compare writes made while the counter runs take effect only at the reload point (edge) or at the bottom turnaround (center). While the clock source is 0 they take effect on the next clock.
- R12: After reset every register and the counter are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate clock enable, one-cycle pulses |
| ext_tick | input | 1 | External clock enable, one-cycle pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_out | output | 8 | Channel output pins |

## Verification
The properties assume that the counter is only reprogrammed with a start value no larger than the modulo value. Otherwise the counting shape is undefined and the step checks would not apply. The stimulus keeps to this. It stops the clock source before rewriting start, modulo or mode, it reloads the counter through its own offset before restarting, and it never changes the counting mode while the counter runs. The idle-level and mask checks assume nothing about the bus, because they hold for any register contents.

// File: rtl/pwm_multi_pkg.sv
// Shared offsets and types of the multi-channel PWM timer.
// Assumes a byte-addressed bus with 32-bit word registers.
package pwm_multi_pkg;

    localparam int unsigned OFS_CTRL      = 'h00;
    localparam int unsigned OFS_COUNT     = 'h04;
    localparam int unsigned OFS_MOD       = 'h08;
    localparam int unsigned OFS_CH_BASE   = 'h0C;
    localparam int unsigned OFS_CH_STRIDE = 8;
    localparam int unsigned OFS_START     = 'h4C;
    localparam int unsigned OFS_IDLE      = 'h5C;
    localparam int unsigned OFS_MASK      = 'h60;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic     center;
        clk_src_e src;
        logic [2:0] ps;
    } tmr_ctrl_t;

    typedef struct packed {
        logic pwm_en;
        logic high_true;
        logic low_true;
    } ch_ctrl_t;

endpackage

// File: rtl/pwm_reg_bank.sv
// Register file of the PWM timer: write decode, buffered values and
// combinational readback. Assumes NUM_CH <= 8 so channel offsets stay
// below the start-value offset, and DATA_W > CNT_W.
module pwm_reg_bank
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    input  logic [CNT_W-1:0]               cnt_val,
    output tmr_ctrl_t                      ctrl,
    output logic [CNT_W-1:0]               mod_buf,
    output logic [CNT_W-1:0]               start_val,
    output logic [NUM_CH-1:0]              idle_lvl,
    output logic [NUM_CH-1:0]              out_mask,
    output ch_ctrl_t [NUM_CH-1:0]          ch_ctl,
    output logic [NUM_CH-1:0][CNT_W-1:0]   ch_val,
    output logic                           cnt_load
);

    logic unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

    // Counter reload request: a write to the counter offset.
    assign cnt_load = wr_en && (addr == ADDR_W'(OFS_COUNT));

    // Register writes, one decode per offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            mod_buf   <= '0;
            start_val <= '0;
            idle_lvl  <= '0;
            out_mask  <= '0;
            ch_ctl    <= '0;
            ch_val    <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFS_CTRL))
                ctrl <= '{center: wdata[5], src: clk_src_e'(wdata[4:3]), ps: wdata[2:0]};
            if (addr == ADDR_W'(OFS_MOD))
                mod_buf <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(OFS_START))
                start_val <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(OFS_IDLE))
                idle_lvl <= wdata[NUM_CH-1:0];
            if (addr == ADDR_W'(OFS_MASK))
                out_mask <= wdata[NUM_CH-1:0];
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr == ADDR_W'(OFS_CH_BASE + n * OFS_CH_STRIDE))
                    ch_ctl[n] <= '{pwm_en: wdata[5], high_true: wdata[3], low_true: wdata[2]};
                if (addr == ADDR_W'(OFS_CH_BASE + n * OFS_CH_STRIDE + 4))
                    ch_val[n] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Readback multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL))  rdata = DATA_W'(ctrl);
        if (addr == ADDR_W'(OFS_COUNT)) rdata = DATA_W'(cnt_val);
        if (addr == ADDR_W'(OFS_MOD))   rdata = DATA_W'(mod_buf);
        if (addr == ADDR_W'(OFS_START)) rdata = DATA_W'(start_val);
        if (addr == ADDR_W'(OFS_IDLE))  rdata = DATA_W'(idle_lvl);
        if (addr == ADDR_W'(OFS_MASK))  rdata = DATA_W'(out_mask);
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(OFS_CH_BASE + n * OFS_CH_STRIDE))
                rdata = DATA_W'({ch_ctl[n].pwm_en, 1'b0, ch_ctl[n].high_true,
                                 ch_ctl[n].low_true, 2'b00});
            if (addr == ADDR_W'(OFS_CH_BASE + n * OFS_CH_STRIDE + 4))
                rdata = DATA_W'(ch_val[n]);
        end
    end

endmodule

// File: rtl/pwm_tick_gen.sv
// Clock-source select and power-of-two prescaler. Produces a one-cycle
// count tick once every 2^ps enables of the selected source.
// Assumes fix_tick and ext_tick are synchronous to clk.
module pwm_tick_gen
    import pwm_multi_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  clk_src_e        src,
    input  logic [PS_W-1:0] ps,
    input  logic            fix_tick,
    input  logic            ext_tick,
    output logic            tick
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic             src_en;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W:0]   lim_w;

    // Select the raw enable of the chosen source.
    always_comb begin
        unique case (src)
            SRC_SYS: src_en = 1'b1;
            SRC_FIX: src_en = fix_tick;
            SRC_EXT: src_en = ext_tick;
            default: src_en = 1'b0;
        endcase
    end

    assign lim_w = ((DIV_W+1)'(1) << ps) - (DIV_W+1)'(1);
    assign tick  = src_en && ({1'b0, pre_q} >= lim_w);

    // Prescaler count of source enables since the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n || src == SRC_OFF)
            pre_q <= '0;
        else if (src_en)
            pre_q <= tick ? '0 : pre_q + 1'b1;
    end

endmodule

// File: rtl/pwm_count_core.sv
// Shared counter: edge-aligned wrap or center-aligned up/down sweep,
// plus the working copy of the modulo value. Flags the period boundary
// at which buffered values are adopted. Assumes start <= modulo.
module pwm_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             center,
    input  logic             run,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] mod_buf,
    output logic [CNT_W-1:0] cnt,
    output logic             up,
    output logic [CNT_W-1:0] mod_act,
    output logic             shadow_upd
);

    logic reload_pt;

    // Period boundary: edge wrap, or bottom turnaround in center mode.
    assign reload_pt  = tick && !cnt_load &&
                        (center ? (!up && cnt <= start_val) : (cnt >= mod_act));
    assign shadow_upd = reload_pt || !run;

    // Counter and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            up  <= 1'b0;
        end else if (cnt_load) begin
            cnt <= start_val;
            up  <= 1'b0;
        end else if (tick) begin
            if (!center) begin
                cnt <= (cnt >= mod_act) ? start_val : cnt + 1'b1;
            end else if (up) begin
                if (cnt >= mod_act) begin
                    up  <= 1'b0;
                    cnt <= (cnt > start_val) ? cnt - 1'b1 : start_val;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt <= start_val) begin
                    up  <= 1'b1;
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // Working modulo value, adopted at the boundary or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mod_act <= '0;
        else if (shadow_upd)
            mod_act <= mod_buf;
    end

endmodule

// File: rtl/pwm_chan.sv
// One compare channel: working compare copy, active-phase decode and
// pin override (mask, idle level, polarity). Assumes shadow_upd comes
// from the shared counter so all channels switch values together.
module pwm_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shadow_upd,
    input  logic [CNT_W-1:0] val_buf,
    input  logic             pwm_en,
    input  logic             low_true,
    input  logic             run,
    input  logic             center,
    input  logic             up,
    input  logic [CNT_W-1:0] cnt,
    input  logic             idle_bit,
    input  logic             mask_bit,
    output logic             pin
);

    logic [CNT_W-1:0] cv_act;
    logic             active;

    // Working compare value, adopted with the modulo value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cv_act <= '0;
        else if (shadow_upd)
            cv_act <= val_buf;
    end

    // Active phase: rising half includes the compare value itself.
    assign active = (center && up) ? (cnt <= cv_act) : (cnt < cv_act);

    // Pin level with mask first, then idle level, then polarity.
    always_comb begin
        if (mask_bit)
            pin = low_true;
        else if (!run || !pwm_en)
            pin = idle_bit;
        else
            pin = active ^ low_true;
    end

endmodule

// File: rtl/pwm_multi_timer.sv
// Top of the multi-channel PWM timer: register bank, tick generator,
// shared counter and one compare channel per output pin.
// Assumes NUM_CH <= 8 (fixed channel offsets) and a synchronous reset.
module pwm_multi_timer
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_tick,
    input  logic              ext_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    tmr_ctrl_t                     ctrl;
    logic [CNT_W-1:0]              mod_buf;
    logic [CNT_W-1:0]              start_val;
    logic [NUM_CH-1:0]             idle_lvl;
    logic [NUM_CH-1:0]             out_mask;
    ch_ctrl_t [NUM_CH-1:0]         ch_ctl;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_val;
    logic                          cnt_load;
    logic                          tick;
    logic [CNT_W-1:0]              cnt_q;
    logic                          up_q;
    logic [CNT_W-1:0]              mod_act;
    logic                          shadow_upd;
    logic                          run;
    logic [NUM_CH-1:0]             low_vec;

    assign run = (ctrl.src != SRC_OFF);

    pwm_reg_bank #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_val(cnt_q), .ctrl(ctrl), .mod_buf(mod_buf),
        .start_val(start_val), .idle_lvl(idle_lvl), .out_mask(out_mask),
        .ch_ctl(ch_ctl), .ch_val(ch_val), .cnt_load(cnt_load)
    );

    pwm_tick_gen #(.PS_W(PS_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .src(ctrl.src), .ps(ctrl.ps),
        .fix_tick(fix_tick), .ext_tick(ext_tick), .tick(tick)
    );

    pwm_count_core #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .center(ctrl.center), .run(run),
        .cnt_load(cnt_load), .start_val(start_val), .mod_buf(mod_buf),
        .cnt(cnt_q), .up(up_q), .mod_act(mod_act), .shadow_upd(shadow_upd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign low_vec[g] = ch_ctl[g].low_true;

        pwm_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .shadow_upd(shadow_upd),
            .val_buf(ch_val[g]), .pwm_en(ch_ctl[g].pwm_en),
            .low_true(ch_ctl[g].low_true), .run(run), .center(ctrl.center),
            .up(up_q), .cnt(cnt_q), .idle_bit(idle_lvl[g]),
            .mask_bit(out_mask[g]), .pin(pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_multi_timer_chk.sv
// Property checker for pwm_multi_timer, attached by bind below.
// Assumes start <= modulo whenever the counter runs.
module pwm_multi_timer_chk
    import pwm_multi_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NUM_CH-1:0] pwm_out,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic              up,
    input logic [CNT_W-1:0]  mod_act,
    input logic [CNT_W-1:0]  start_val,
    input logic              center,
    input logic [1:0]        src,
    input logic [NUM_CH-1:0] idle_lvl,
    input logic [NUM_CH-1:0] out_mask,
    input logic [NUM_CH-1:0] low_vec
);

    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == ADDR_W'(OFS_COUNT));

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd0 && !cnt_wr) |=> $stable(cnt));

    a_r3_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (src != 2'd0));

    a_r5_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !center && !cnt_wr && cnt < mod_act) |=> (cnt == $past(cnt) + 1'b1));

    a_r6_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && center && up && !cnt_wr && cnt >= mod_act && cnt > start_val)
        |=> (!up && cnt == $past(cnt) - 1'b1));

    a_r9_mask_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out ^ low_vec) & out_mask) == '0);

    a_r10_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd0) |-> (((pwm_out ^ idle_lvl) & ~out_mask) == '0));

endmodule

bind pwm_multi_timer pwm_multi_timer_chk #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .pwm_out(pwm_out),
    .tick(tick), .cnt(cnt_q), .up(up_q), .mod_act(mod_act),
    .start_val(start_val), .center(ctrl.center), .src(ctrl.src),
    .idle_lvl(idle_lvl), .out_mask(out_mask), .low_vec(low_vec)
);

// File: tb/pwm_multi_timer_tb_top.sv
// Directed bench for pwm_multi_timer: one task per scenario.
module pwm_multi_timer_tb_top;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_COUNT = 8'h04;
    localparam logic [7:0] A_MOD   = 8'h08;
    localparam logic [7:0] A_START = 8'h4C;
    localparam logic [7:0] A_IDLE  = 8'h5C;
    localparam logic [7:0] A_MASK  = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fix_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pwm_out;

    int checks = 0;
    int errs   = 0;
    int hi [8];
    bit done   = 1'b0;

    pwm_multi_timer dut_i (
        .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    // Fixed-rate enable: one cycle high out of three.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == 2) ? 0 : div + 1;
            fix_tick = (div == 0);
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [7:0] ctl_a(input int n);
        return 8'(12 + 8 * n);
    endfunction

    function automatic logic [7:0] val_a(input int n);
        return 8'(16 + 8 * n);
    endfunction

    task automatic window(input int n);
        for (int c = 0; c < 8; c++) hi[c] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int c = 0; c < 8; c++) hi[c] += int'(pwm_out[c]);
        end
    endtask

    task automatic cfg(input int start, input int modv);
        wr(A_CTRL, 32'h0);
        wr(A_MASK, 32'h0);
        wr(A_START, 32'(start));
        wr(A_MOD, 32'(modv));
    endtask

    task automatic set_ch(input int n, input int ctl, input int val);
        wr(ctl_a(n), 32'(ctl));
        wr(val_a(n), 32'(val));
    endtask

    task automatic go(input logic [31:0] ctrl_word);
        wr(A_COUNT, 32'h0);
        wr(A_CTRL, ctrl_word);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v);  chk("R12 ctrl after reset", v, 32'h0);
        rd(A_COUNT, v); chk("R12 counter after reset", v, 32'h0);
        rd(A_MOD, v);   chk("R12 modulo after reset", v, 32'h0);
        chk("R12 outputs after reset", 32'(pwm_out), 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_CTRL, 32'h25);
        wr(A_MOD, 32'h1234);
        wr(A_START, 32'h4);
        wr(ctl_a(7), 32'h2C);
        wr(val_a(7), 32'hBEEF);
        wr(A_MASK, 32'h81);
        rd(A_CTRL, v);   chk("R1 ctrl readback", v, 32'h25);
        rd(A_MOD, v);    chk("R1 modulo readback", v, 32'h1234);
        rd(ctl_a(7), v); chk("R1 channel mode readback", v, 32'h2C);
        rd(val_a(7), v); chk("R1 channel compare readback", v, 32'hBEEF);
        rd(A_START, v);  chk("R1 start readback", v, 32'h4);
        rd(A_MASK, v);   chk("R1 mask readback", v, 32'h81);
        rd(8'h50, v);    chk("R1 unmapped reads zero", v, 32'h0);
        wr(A_COUNT, 32'h0);
        rd(A_COUNT, v);  chk("R4 counter write loads start", v, 32'h4);
        wr(A_MASK, 32'h0);
        wr(ctl_a(7), 32'h0);
        wr(A_START, 32'h0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_edge();
        cfg(0, 9);
        wr(A_IDLE, 32'h10);
        set_ch(0, 'h28, 3);
        set_ch(1, 'h28, 0);
        set_ch(2, 'h28, 12);
        set_ch(3, 'h24, 3);
        set_ch(4, 'h00, 5);
        @(negedge clk);
        chk("R10 stopped drives idle levels", 32'(pwm_out), 32'h10);
        go(32'h08);
        window(20);
        chk("R5 edge width 3 of 10", hi[0], 6);
        chk("R7 edge compare zero is 0%", hi[1], 0);
        chk("R7 edge compare above modulo is 100%", hi[2], 20);
        chk("R8 low-true inverted width", hi[3], 14);
        chk("R10 PWM-disabled channel drives idle", hi[4], 20);
    endtask

    task automatic t_edge_offset();
        cfg(4, 11);
        set_ch(0, 'h28, 7);
        set_ch(1, 'h28, 4);
        set_ch(2, 'h28, 2);
        set_ch(3, 'h24, 3);
        go(32'h08);
        window(16);
        chk("R5 edge start offset width", hi[0], 6);
        chk("R7 compare equal to start is 0%", hi[1], 0);
        chk("R7 compare below start is 0%", hi[2], 0);
        chk("R8 low-true 0% stays high", hi[3], 16);
    endtask

    task automatic t_center();
        cfg(0, 6);
        set_ch(0, 'h28, 2);
        set_ch(1, 'h28, 0);
        set_ch(2, 'h28, 6);
        set_ch(3, 'h24, 2);
        go(32'h28);
        window(24);
        chk("R6 center width 4 of 12", hi[0], 8);
        chk("R7 center compare zero is 0%", hi[1], 0);
        chk("R7 center compare at modulo is 100%", hi[2], 24);
        chk("R8 center low-true width", hi[3], 16);
    endtask

    task automatic t_center_offset();
        cfg(2, 6);
        set_ch(0, 'h28, 4);
        set_ch(1, 'h28, 2);
        set_ch(2, 'h28, 9);
        set_ch(3, 'h24, 4);
        go(32'h28);
        window(16);
        chk("R6 center start offset width", hi[0], 8);
        chk("R7 center compare at start is 0%", hi[1], 0);
        chk("R7 center compare above modulo", hi[2], 16);
        chk("R6 center low-true offset width", hi[3], 8);
    endtask

    task automatic t_prescale();
        cfg(0, 3);
        set_ch(0, 'h28, 1);
        set_ch(2, 'h28, 2);
        go(32'h0A);
        window(32);
        chk("R3 divide-by-4 width 1 of 4 ticks", hi[0], 8);
        chk("R3 divide-by-4 width 2 of 4 ticks", hi[2], 16);
    endtask

    task automatic t_sources();
        logic [31:0] a, b;
        cfg(0, 3);
        set_ch(0, 'h28, 2);
        go(32'h10);
        window(24);
        chk("R2 fixed enable source width", hi[0], 12);
        wr(A_CTRL, 32'h18);
        rd(A_COUNT, a);
        window(6);
        rd(A_COUNT, b);
        chk("R2 external source idle freezes counter", b, a);
        wr(A_CTRL, 32'h00);
        rd(A_COUNT, a);
        window(5);
        rd(A_COUNT, b);
        chk("R2 source off freezes counter", b, a);
        chk("R10 stopped outputs return to idle", 32'(pwm_out), 32'h10);
    endtask

    task automatic t_mask();
        cfg(0, 9);
        set_ch(0, 'h28, 3);
        set_ch(2, 'h28, 12);
        set_ch(3, 'h24, 3);
        go(32'h08);
        wr(A_MASK, 32'h0F);
        window(20);
        chk("R9 masked high-true channel low", hi[0], 0);
        chk("R9 masked 100% channel low", hi[2], 0);
        chk("R9 masked low-true channel high", hi[3], 20);
        chk("R9 unmasked channel keeps idle", hi[4], 20);
        wr(A_MASK, 32'hFF);
        @(negedge clk);
        chk("R9 full mask gives inactive levels", 32'(pwm_out), 32'h08);
    endtask

    task automatic t_buffer();
        logic [31:0] v;
        int guard = 0;
        cfg(0, 9);
        set_ch(0, 'h28, 3);
        go(32'h08);
        do begin
            rd(A_COUNT, v);
            guard++;
        end while (v != 32'd3 && guard < 50);
        wr(val_a(0), 32'd8);
        window(4);
        chk("R11 compare write waits for reload", hi[0], 0);
        rd(val_a(0), v);
        chk("R1 buffered compare reads back", v, 32'd8);
        window(10);
        chk("R11 new compare applies next period", hi[0], 8);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_edge();
        t_edge_offset();
        t_center();
        t_center_offset();
        t_prescale();
        t_sources();
        t_mask();
        t_buffer();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule